// File: doc/BRIEF.md
# Multi-Stage Digital Trigger Sequencer

This block watches a word of digital channels, one new sample per clock, and raises a trigger after a chain of up to four conditions has been seen in order. Each stage of the chain gives every channel its own test. A channel can be ignored, or it can be required to sit low, sit high, or show a rising or falling edge. A stage is met only when all of its tested channels pass on the same sample.

After a stage is met, a programmable delay runs out before the next stage starts to look at the input. When the last stage of the chain is met and its own delay has run out, the block gives a single-cycle trigger pulse. It then stays in a fired state until software re-arms it. A stage-count setting lets shorter chains of one, two or three stages fire on an earlier stage.

Edges are found by comparing each sample with the one registered on the clock before. That register runs on every clock, including the clock that carries the arm strobe. The number of the stage currently sought, or currently delaying, is brought out so that progress through the chain can be seen.

Top module: `dig_trig_seq`

## Requirements
- R1: After reset, and before the first arm strobe, `trigPulse` is 0 and `curStage` is 0, whatever the inputs do.
- R2: The 3-bit code for stage s, channel c lies at `stageCond[(s*NUM_CH+c)*3 +: 3]`. The codes are: 0 = ignore; 1 = sample bit is 0; 2 = sample bit is 1; 3 = rising, meaning the bit was 0 on the previous clock and is 1 now; 4 = falling, meaning it was 1 and is now 0. Codes 5 to 7 never pass. The previous sample is the one presented on the clock before, even when that clock carried the arm strobe.
- R3: A stage is met only when every channel whose code is not 0 passes its test on one and the same sample.
- R4: Stages are sought strictly in order, starting at 0. `curStage` shows the stage being sought or delaying, and it never moves up by more than one per clock. Only the stage shown can be met.
- R5: The delay of stage s is `stageDelay[s*DELAY_W +: DELAY_W]`, called D. When stage s is met on the sample of cycle k, the next stage (or the trigger) acts on the sample of cycle k+1+D. Samples presented during the delay have no effect.
- R6: `lastStage` (0 to 3) is the index of the final stage. When that stage is met and its delay has run out, `trigPulse` is high for exactly one cycle. In that cycle `curStage` equals `lastStage`. With D = 0, the pulse is visible right after the clock edge that samples the matching word.
- R7: After firing, the block gives no further pulse and `curStage` holds until the next arm strobe.
- R8: An arm strobe, from any state (idle, seeking, delaying or fired), restarts the chain at stage 0 and drops all progress. The sample presented together with the strobe is not tested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleIn | input | NUM_CH | Digital channel sample for this clock |
| stageCond | input | NUM_STAGES*NUM_CH*3 | Per-stage, per-channel condition codes |
| stageDelay | input | NUM_STAGES*DELAY_W | Per-stage delay in clocks |
| lastStage | input | STAGE_W | Index of the final stage of the chain |
| armStrobe | input | 1 | Restart the chain at stage 0 |
| trigPulse | output | 1 | One-cycle trigger pulse |
| curStage | output | STAGE_W | Stage currently sought or delaying |

## Verification
On every cycle, the assertions check the shape of the chain's progress: the pulse lasts only one cycle, the stage never jumps by more than one, an arm strobe returns the block to stage 0, and a fired block neither moves nor fires again before re-arming. Three things depend on particular sample sequences and delay settings, so only the bench scenarios can show them: that each condition code, including an edge across the arm clock, passes exactly when it should; that all tested channels must agree on one sample; and that the delay shifts the next evaluation by exactly D cycles. The random runs compare every cycle against a bench model of the chain.

// File: rtl/dig_trig_pkg.sv
package dig_trig_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    COND_ANY  = 3'd0,
    COND_LOW  = 3'd1,
    COND_HIGH = 3'd2,
    COND_RISE = 3'd3,
    COND_FALL = 3'd4
  } condCode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEEK  = 2'd1,
    ST_DELAY = 2'd2,
    ST_FIRED = 2'd3
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDelay;
    logic stepDelay;
  } dpCtrl_t;

  function automatic logic condMet(input logic [CODE_W-1:0] code,
                                   input logic cur, input logic prev);
    logic ok;
    case (code)
      COND_ANY:  ok = 1'b1;
      COND_LOW:  ok = ~cur;
      COND_HIGH: ok = cur;
      COND_RISE: ok = ~prev & cur;
      COND_FALL: ok = prev & ~cur;
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/dig_trig_dp.sv
module dig_trig_dp
  import dig_trig_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int NUM_STAGES = 4,
  parameter int DELAY_W    = 16,
  parameter int STAGE_W    = 2
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_CH-1:0]                    sampleIn,
  input  logic [NUM_STAGES*NUM_CH*CODE_W-1:0]  stageCond,
  input  logic [NUM_STAGES*DELAY_W-1:0]        stageDelay,
  input  logic [STAGE_W-1:0]                   selStage,
  input  dpCtrl_t                              ctrl,
  output logic                                 stageHit,
  output logic                                 delayZero,
  output logic                                 delayLast
);

  logic [NUM_CH-1:0]     prevSample;
  logic [NUM_CH-1:0]     chanOk [NUM_STAGES];
  logic [NUM_STAGES-1:0] stageMatch;
  logic [DELAY_W-1:0]    delayArr [NUM_STAGES];
  logic [DELAY_W-1:0]    selDelay;
  logic [DELAY_W-1:0]    delayCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSample <= '0;
    else       prevSample <= sampleIn;
  end

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      assign chanOk[s][c] = condMet(stageCond[(s*NUM_CH+c)*CODE_W +: CODE_W],
                                    sampleIn[c], prevSample[c]);
    end
    assign stageMatch[s] = &chanOk[s];
    assign delayArr[s]   = stageDelay[s*DELAY_W +: DELAY_W];
  end

  assign selDelay  = delayArr[selStage];
  assign stageHit  = stageMatch[selStage];
  assign delayZero = (selDelay == '0);
  assign delayLast = (delayCnt == DELAY_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               delayCnt <= '0;
    else if (ctrl.loadDelay) delayCnt <= selDelay;
    else if (ctrl.stepDelay) delayCnt <= delayCnt - DELAY_W'(1);
  end

endmodule

// File: rtl/dig_trig_ctrl.sv
module dig_trig_ctrl
  import dig_trig_pkg::*;
#(
  parameter int STAGE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               armStrobe,
  input  logic [STAGE_W-1:0] lastStage,
  input  logic               stageHit,
  input  logic               delayZero,
  input  logic               delayLast,
  output dpCtrl_t            ctrl,
  output logic [STAGE_W-1:0] curStage,
  output logic               trigPulse
);

  seqState_e          state, nState;
  logic [STAGE_W-1:0] stage, nStage;
  logic               nPulse;
  logic               advance;

  always_comb begin
    nState  = state;
    nStage  = stage;
    nPulse  = 1'b0;
    advance = 1'b0;
    ctrl    = '0;
    if (armStrobe) begin
      nState = ST_SEEK;
      nStage = '0;
    end else begin
      case (state)
        ST_SEEK: begin
          if (stageHit) begin
            if (delayZero) advance = 1'b1;
            else begin
              nState         = ST_DELAY;
              ctrl.loadDelay = 1'b1;
            end
          end
        end
        ST_DELAY: begin
          if (delayLast) advance = 1'b1;
          else           ctrl.stepDelay = 1'b1;
        end
        default: ;
      endcase
      if (advance) begin
        if (stage == lastStage) begin
          nState = ST_FIRED;
          nPulse = 1'b1;
        end else begin
          nState = ST_SEEK;
          nStage = stage + STAGE_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stage     <= '0;
      trigPulse <= 1'b0;
    end else begin
      state     <= nState;
      stage     <= nStage;
      trigPulse <= nPulse;
    end
  end

  assign curStage = stage;

endmodule

// File: rtl/dig_trig_seq.sv
module dig_trig_seq
  import dig_trig_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int NUM_STAGES = 4,
  parameter int DELAY_W    = 16,
  localparam int STAGE_W   = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
  localparam int COND_BITS = NUM_STAGES * NUM_CH * CODE_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0]             sampleIn,
  input  logic [COND_BITS-1:0]          stageCond,
  input  logic [NUM_STAGES*DELAY_W-1:0] stageDelay,
  input  logic [STAGE_W-1:0]            lastStage,
  input  logic                          armStrobe,
  output logic                          trigPulse,
  output logic [STAGE_W-1:0]            curStage
);

  dpCtrl_t dpCtrl;
  logic    stageHit;
  logic    delayZero;
  logic    delayLast;

  dig_trig_dp #(
    .NUM_CH(NUM_CH), .NUM_STAGES(NUM_STAGES),
    .DELAY_W(DELAY_W), .STAGE_W(STAGE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn),
    .stageCond(stageCond), .stageDelay(stageDelay),
    .selStage(curStage), .ctrl(dpCtrl),
    .stageHit(stageHit), .delayZero(delayZero), .delayLast(delayLast)
  );

  dig_trig_ctrl #(.STAGE_W(STAGE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .armStrobe(armStrobe), .lastStage(lastStage),
    .stageHit(stageHit), .delayZero(delayZero), .delayLast(delayLast),
    .ctrl(dpCtrl), .curStage(curStage), .trigPulse(trigPulse)
  );

endmodule

// File: rtl/dig_trig_chk.sv
module dig_trig_chk #(
  parameter int STAGE_W = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               armStrobe,
  input logic               trigPulse,
  input logic [STAGE_W-1:0] curStage,
  input logic [STAGE_W-1:0] lastStage
);

  logic firedSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          firedSeen <= 1'b0;
    else if (armStrobe) firedSeen <= 1'b0;
    else if (trigPulse) firedSeen <= 1'b1;
  end

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);

  // R6
  pulse_at_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> (curStage == lastStage));

  // R7
  no_refire_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> !firedSeen);

  // R7
  fired_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (firedSeen && !armStrobe) |=> $stable(curStage));

  // R8
  arm_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    armStrobe |=> (curStage == '0 && !trigPulse));

  // R4
  stage_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armStrobe |=> (curStage == $past(curStage) ||
                    curStage == $past(curStage) + STAGE_W'(1)));

endmodule

bind dig_trig_seq dig_trig_chk #(.STAGE_W(STAGE_W)) u_chk (
  .clk(clk), .rstN(rstN), .armStrobe(armStrobe), .trigPulse(trigPulse),
  .curStage(curStage), .lastStage(lastStage)
);

// File: tb/tb_dig_trig_seq.sv
module tb_dig_trig_seq;

  localparam int NCH = 16;
  localparam int NST = 4;
  localparam int DW  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NCH-1:0]    sampleIn = '0;
  logic [NST*NCH*3-1:0] stageCond = '0;
  logic [NST*DW-1:0] stageDelay = '0;
  logic [1:0]        lastStage = '0;
  logic              armStrobe = 1'b0;
  logic              trigPulse;
  logic [1:0]        curStage;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // bench model of the chain
  int mState = 0;  // 0 idle, 1 seek, 2 delay, 3 fired
  int mStage = 0;
  int mCnt = 0;
  int mPulse = 0;
  logic [NCH-1:0] mPrev = '0;

  always #4 clk = ~clk;

  dig_trig_seq dut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .stageCond(stageCond),
    .stageDelay(stageDelay), .lastStage(lastStage), .armStrobe(armStrobe),
    .trigPulse(trigPulse), .curStage(curStage)
  );

  function automatic bit passes(int code, logic cur, logic prev);
    if (code == 0) return 1;
    if (code == 1) return cur == 1'b0;
    if (code == 2) return cur == 1'b1;
    if (code == 3) return prev == 1'b0 && cur == 1'b1;
    if (code == 4) return prev == 1'b1 && cur == 1'b0;
    return 0;
  endfunction

  function automatic bit stageMet(int s, logic [NCH-1:0] smp, logic [NCH-1:0] prv);
    for (int c = 0; c < NCH; c++)
      if (!passes(int'(stageCond[(s*NCH+c)*3 +: 3]), smp[c], prv[c])) return 0;
    return 1;
  endfunction

  function automatic int delayOf(int s);
    return int'(stageDelay[s*DW +: DW]);
  endfunction

  task automatic modelAdvance();
    if (mStage == int'(lastStage)) begin
      mState = 3;
      mPulse = 1;
    end else begin
      mStage = mStage + 1;
      mState = 1;
    end
  endtask

  task automatic modelStep(logic [NCH-1:0] smp, logic arm);
    mPulse = 0;
    if (arm) begin
      mState = 1;
      mStage = 0;
    end else if (mState == 1) begin
      if (stageMet(mStage, smp, mPrev)) begin
        if (delayOf(mStage) == 0) modelAdvance();
        else begin
          mState = 2;
          mCnt = delayOf(mStage);
        end
      end
    end else if (mState == 2) begin
      if (mCnt == 1) modelAdvance();
      else mCnt = mCnt - 1;
    end
    mPrev = smp;
  endtask

  task automatic checkVal(string tag, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic runCycle(logic [NCH-1:0] smp, logic arm, string tag);
    @(negedge clk);
    sampleIn  = smp;
    armStrobe = arm;
    modelStep(smp, arm);
    @(posedge clk);
    #1;
    checkVal({tag, " pulse"}, int'(trigPulse), mPulse);
    checkVal({tag, " stage"}, int'(curStage), mStage);
  endtask

  task automatic setCode(int s, int c, int code);
    stageCond[(s*NCH+c)*3 +: 3] = 3'(code);
  endtask

  // one quiet cycle, then new configuration, then arm
  task automatic configure(int last);
    runCycle('0, 1'b0, "R7 settle");
    @(negedge clk);
    stageCond  = '0;
    stageDelay = '0;
    lastStage  = 2'(last);
  endtask

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    checkVal("R1 reset pulse", int'(trigPulse), 0);
    checkVal("R1 reset stage", int'(curStage), 0);

    // R1: everything passes, but no arm yet
    for (int i = 0; i < 5; i++) runCycle(16'(i * 7), 1'b0, "R1 unarmed");
    checkVal("R1 unarmed pulse", int'(trigPulse), 0);

    // R2 level high, single stage (R6)
    configure(0);
    setCode(0, 3, 2);
    runCycle('0, 1'b1, "R8 arm");
    for (int i = 0; i < 3; i++) runCycle('0, 1'b0, "R2 high wait");
    runCycle(16'h0008, 1'b0, "R2 high hit");
    checkVal("R6 pulse on hit", int'(trigPulse), 1);
    runCycle(16'h0008, 1'b0, "R7 hold");
    checkVal("R7 no second pulse", int'(trigPulse), 0);
    checkVal("R7 stage held", int'(curStage), 0);

    // R2 rising across the arm clock
    configure(0);
    setCode(0, 5, 3);
    runCycle('0, 1'b1, "R8 arm");
    runCycle(16'h0020, 1'b0, "R2 rise");
    checkVal("R2 rise pulse", int'(trigPulse), 1);

    // R2 falling
    configure(0);
    setCode(0, 5, 4);
    runCycle(16'h0020, 1'b1, "R8 arm");
    runCycle(16'h0020, 1'b0, "R2 fall wait");
    checkVal("R2 fall not yet", int'(trigPulse), 0);
    runCycle('0, 1'b0, "R2 fall");
    checkVal("R2 fall pulse", int'(trigPulse), 1);

    // R2 low
    configure(0);
    setCode(0, 7, 1);
    runCycle('1, 1'b1, "R8 arm");
    runCycle('1, 1'b0, "R2 low wait");
    checkVal("R2 low not yet", int'(trigPulse), 0);
    runCycle(16'hFF7F, 1'b0, "R2 low");
    checkVal("R2 low pulse", int'(trigPulse), 1);

    // R3 all tested channels on the same sample
    configure(0);
    setCode(0, 0, 2);
    setCode(0, 1, 1);
    runCycle('0, 1'b1, "R8 arm");
    runCycle(16'h0003, 1'b0, "R3 partial a");
    checkVal("R3 partial a pulse", int'(trigPulse), 0);
    runCycle(16'h0000, 1'b0, "R3 partial b");
    checkVal("R3 partial b pulse", int'(trigPulse), 0);
    runCycle(16'h0001, 1'b0, "R3 full");
    checkVal("R3 full pulse", int'(trigPulse), 1);

    // R2 reserved code never passes
    configure(0);
    setCode(0, 2, 5);
    runCycle('0, 1'b1, "R8 arm");
    for (int i = 0; i < 6; i++) begin
      runCycle(16'($urandom), 1'b0, "R2 reserved");
      checkVal("R2 reserved no pulse", int'(trigPulse), 0);
    end

    // R5 / R4 three-stage chain with delays
    configure(2);
    setCode(0, 0, 2); stageDelay[0*DW +: DW] = 16'd2;
    setCode(1, 1, 2);
    setCode(2, 2, 2); stageDelay[2*DW +: DW] = 16'd1;
    runCycle('0, 1'b1, "R8 arm");
    runCycle(16'h0001, 1'b0, "R5 s0 hit");
    checkVal("R5 delaying stage", int'(curStage), 0);
    runCycle(16'h0006, 1'b0, "R5 ignored 1");
    checkVal("R5 still stage 0", int'(curStage), 0);
    runCycle(16'h0006, 1'b0, "R5 ignored 2");
    checkVal("R4 now stage 1", int'(curStage), 1);
    runCycle(16'h0002, 1'b0, "R4 s1 hit");
    checkVal("R4 now stage 2", int'(curStage), 2);
    runCycle(16'h0004, 1'b0, "R5 s2 hit");
    checkVal("R5 last delay no pulse", int'(trigPulse), 0);
    runCycle(16'h0000, 1'b0, "R5 last expire");
    checkVal("R6 chain pulse", int'(trigPulse), 1);
    checkVal("R6 chain stage", int'(curStage), 2);

    // R8 arm during a delay
    runCycle('0, 1'b1, "R8 re-arm");
    runCycle(16'h0001, 1'b0, "R8 s0 hit");
    runCycle(16'h0000, 1'b1, "R8 arm in delay");
    checkVal("R8 back to 0", int'(curStage), 0);
    runCycle(16'h0002, 1'b0, "R8 progress dropped");
    checkVal("R8 stays 0", int'(curStage), 0);

    // R4 random chains against the model
    for (int run = 0; run < 60; run++) begin
      configure(int'($urandom % 4));
      for (int s = 0; s < NST; s++) begin
        stageDelay[s*DW +: DW] = 16'($urandom % 5);
        for (int c = 0; c < NCH; c++)
          setCode(s, c, ($urandom % 10 < 7) ? 0 : int'(1 + $urandom % 4));
      end
      runCycle(16'($urandom), 1'b1, "R8 arm");
      for (int k = 0; k < 150; k++)
        runCycle(16'($urandom), ($urandom % 60) == 0, "R4 random");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : watchdog
    #(8 * 190000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule